// File: doc/BRIEF.md
# 1-Wire ROM Search Engine

This block enumerates every 64-bit ROM code present on a 1-Wire bus by walking the binary identification tree. It does not generate bus timing itself. Instead it drives a separate time-slot engine through a simple request/acknowledge port. That port offers four operations: bus reset with presence detect, write one byte, read one bit and write one bit.

A search begins on a one-cycle `start` pulse. Each pass starts with a reset and the search command byte. The pass then visits all 64 bit positions. At each position the block reads the bit and its complement from the bus, picks a direction and writes that direction back, so that devices on the other branch drop out.

Branch choice across passes relies on two indices, the deepest unexplored zero branch and the one before it, plus a flag that records whether any collision was ever seen. Each finished code is checked against the 1-Wire CRC8 before it is streamed out on a 64-bit port with a one-cycle strobe. A running device count is kept alongside. The search ends with a one-cycle `done` and a held status of "last device" or "error".

Top module: `rom_search_engine`

## Requirements
- R1: While idle, a `start` pulse launches a search, and every pass begins with a reset request (`cmd_op` = 0). If the reset completes with `cmd_rbit` = 0 (no presence), the search finishes with `status` = 2 (error), `dev_count` = 0 and no code emitted.
- R2: After a reset with presence, the block requests a byte write (`cmd_op` = 1) with `cmd_data` = 0xF0. It then performs 64 bit steps, each made of two bit reads (`cmd_op` = 2) followed by one bit write (`cmd_op` = 3) carrying the direction in `cmd_data[0]`. A request stays unchanged until `cmd_done` acknowledges it.
- R3: In each step the first read is the direct bit and the second is the complement. If both read as 1, the search stops at once with `status` = 2 and `dev_count` = 0.
- R4: When exactly one of the pair is 1, all remaining devices agree at that position. The direct bit is stored and written back.
- R5: When both bits of the pair read 0 (a collision), the direction is chosen as follows.
  - On the first pass, direction 0 is always taken.
  - On later passes, a position below the last zero branch repeats the previous code's bit.
  - A position equal to the last zero branch takes 1.
  - A position above the last zero branch takes 0.
  - As a result, devices are reported in ascending order of their codes read from bit 0 as most significant.
- R6: Code bit i is the i-th bit received (byte k occupies bits 8k..8k+7, LSB first). Byte 7 must equal the CRC8 of bytes 0..6, computed with the reflected polynomial 0x8C, initial value 0, bits taken LSB first (a lone byte 0x01 gives 0x5E). On a mismatch the code is not emitted, and the search ends with `status` = 2 and `dev_count` = 0.
- R7: Each accepted code appears on `rom_code` with `rom_valid` high for one cycle. In that same cycle `dev_count` shows the incremented count, which saturates at 255.
- R8: The search finishes with a one-cycle `done`. `status` = 1 (last device) is returned once a pass ends with no zero branch left to explore. `status` holds until the next `start`, `busy` is high from start to done, and after reset the outputs are idle with `status` = 0.
- R9: A `start` pulse while `busy` is high has no effect on the search in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse launching a search |
| cmd_valid | output | 1 | Request to the slot engine is pending |
| cmd_op | output | 2 | 0 reset, 1 write byte, 2 read bit, 3 write bit |
| cmd_data | output | 8 | Byte to write, or direction in bit 0 |
| cmd_done | input | 1 | One-cycle acknowledge of the pending request |
| cmd_rbit | input | 1 | Presence (reset) or sampled bus bit (read) |
| rom_valid | output | 1 | One-cycle strobe of an accepted code |
| rom_code | output | 64 | Discovered ROM code |
| dev_count | output | 8 | Accepted codes in the current search |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search strobe |
| status | output | 2 | 0 none, 1 last device, 2 error |

## Verification
The assertions assume that the slot engine raises `cmd_done` only while `cmd_valid` is high, for exactly one cycle per request. They also assume that read results reflect a wired-AND of devices that all obey the bit-write elimination rule. The bench's slot model meets both assumptions. It acknowledges each request after a random delay and recomputes the bus response from the set of still-active modelled devices. Error paths come from dedicated setups rather than random bus glitches: an empty bus, a bus that shows presence but no devices, and a device whose check byte is wrong.

// File: rtl/rse_pkg.sv
package rse_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WBYTE = 2'd1,
        OP_RBIT  = 2'd2,
        OP_WBIT  = 2'd3
    } slot_op_e;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_LAST  = 2'd1,
        RES_ERROR = 2'd2
    } search_res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_CMD,
        ST_RD_D,
        ST_RD_C,
        ST_WR,
        ST_CHECK
    } search_state_e;

    localparam logic [7:0] CRC_POLY = 8'h8C;

    // One serial CRC8 step, data bit taken LSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
        logic fb;
        logic [7:0] n;
        fb = c[0] ^ b;
        n  = c >> 1;
        if (fb) n = n ^ CRC_POLY;
        return n;
    endfunction

    // Byte-wise CRC8 over the low seven bytes of a 64-bit code.
    function automatic logic [7:0] crc8_code7(input logic [63:0] code);
        logic [7:0] c;
        c = 8'h00;
        for (int k = 0; k < 7; k++) begin
            c = c ^ code[8*k +: 8];
            for (int j = 0; j < 8; j++) begin
                c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/rse_crc8.sv
module rse_crc8
    import rse_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic       bit_in,
    output logic [7:0] crc_o
);
    logic [7:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_q <= 8'h00;
        end else if (en) begin
            crc_q <= crc8_step(crc_q, bit_in);
        end
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/rse_code_store.sv
module rse_code_store #(
    parameter int ROM_BITS = 64,
    localparam int POS_W   = $clog2(ROM_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_code,
    input  logic                clr_path,
    input  logic                store_en,
    input  logic [POS_W-1:0]    pos,
    input  logic                bit_in,
    input  logic                save_path,
    output logic [ROM_BITS-1:0] code_o,
    output logic                path_bit_o
);
    logic [ROM_BITS-1:0] code_q;
    logic [ROM_BITS-1:0] path_q;

    for (genvar g = 0; g < ROM_BITS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clr_code) begin
                code_q[g] <= 1'b0;
            end else if (store_en && (int'(pos) == g)) begin
                code_q[g] <= bit_in;
            end
        end

        always_ff @(posedge clk) begin
            if (rst || clr_path) begin
                path_q[g] <= 1'b0;
            end else if (save_path) begin
                path_q[g] <= code_q[g];
            end
        end
    end

    assign code_o     = code_q;
    assign path_bit_o = path_q[pos];
endmodule

// File: rtl/rse_branch.sv
module rse_branch #(
    parameter int ROM_BITS = 64,
    localparam int POS_W   = $clog2(ROM_BITS),
    localparam int IDX_W   = POS_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             upd,
    input  logic             first_pass,
    input  logic [POS_W-1:0] pos,
    input  logic             path_bit,
    output logic             dir_o,
    output logic             zero_o
);
    logic signed [IDX_W-1:0] lz_q;
    logic signed [IDX_W-1:0] pz_q;
    logic signed [IDX_W-1:0] lz_d;
    logic signed [IDX_W-1:0] pz_d;
    logic signed [IDX_W-1:0] pos_s;

    assign pos_s = $signed({2'b00, pos});

    always_comb begin
        dir_o  = 1'b0;
        zero_o = 1'b0;
        lz_d   = lz_q;
        pz_d   = pz_q;
        if (first_pass || (pos_s > lz_q)) begin
            // descend into a new zero branch
            dir_o  = 1'b0;
            zero_o = 1'b1;
            pz_d   = lz_q;
            lz_d   = pos_s;
        end else if (pos_s == lz_q) begin
            // the branch explored last time now takes its one side
            dir_o  = 1'b1;
            lz_d   = pz_q;
        end else begin
            dir_o  = path_bit;
            if (!path_bit) begin
                zero_o = 1'b1;
                pz_d   = pos_s;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || init) begin
            lz_q <= '1;
            pz_q <= '1;
        end else if (upd) begin
            lz_q <= lz_d;
            pz_q <= pz_d;
        end
    end
endmodule

// File: rtl/rom_search_engine.sv
module rom_search_engine
    import rse_pkg::*;
#(
    parameter int          ROM_BITS   = 64,
    parameter logic [7:0]  SEARCH_CMD = 8'hF0,
    parameter int          CNT_W      = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    output logic                cmd_valid,
    output logic [1:0]          cmd_op,
    output logic [7:0]          cmd_data,
    input  logic                cmd_done,
    input  logic                cmd_rbit,
    output logic                rom_valid,
    output logic [ROM_BITS-1:0] rom_code,
    output logic [CNT_W-1:0]    dev_count,
    output logic                busy,
    output logic                done,
    output logic [1:0]          status
);
    localparam int             POS_W    = $clog2(ROM_BITS);
    localparam int             CRC_BITS = ROM_BITS - 8;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(ROM_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

    search_state_e    state_q;
    logic [POS_W-1:0] pos_q;
    logic             dbit_q;
    logic             dir_q;
    logic             single_q;
    logic             first_q;
    logic             more_q;
    logic [1:0]       status_q;
    logic [CNT_W-1:0] count_q;
    logic             rom_valid_q;
    logic             done_q;

    logic             pair_err;
    logic             collide;
    logic             store_en;
    logic             store_bit;
    logic             br_dir;
    logic             br_zero;
    logic             path_bit;
    logic [7:0]       crc_val;
    logic             crc_ok;
    logic             launch;
    logic             pass_clr;
    logic             accept;

    assign launch    = (state_q == ST_IDLE) && start;
    assign pass_clr  = (state_q == ST_RESET) && cmd_done && cmd_rbit;
    assign pair_err  = (state_q == ST_RD_C) && cmd_done && dbit_q && cmd_rbit;
    assign collide   = (state_q == ST_RD_C) && cmd_done && !dbit_q && !cmd_rbit;
    assign store_en  = (state_q == ST_RD_C) && cmd_done && !pair_err;
    assign store_bit = collide ? br_dir : dbit_q;
    assign crc_ok    = (crc_val == rom_code[ROM_BITS-1 -: 8]);
    assign accept    = (state_q == ST_CHECK) && crc_ok;

    rse_crc8 u_crc (
        .clk    (clk),
        .rst    (rst),
        .clr    (pass_clr),
        .en     (store_en && (int'(pos_q) < CRC_BITS)),
        .bit_in (store_bit),
        .crc_o  (crc_val)
    );

    rse_code_store #(.ROM_BITS(ROM_BITS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .clr_code   (pass_clr),
        .clr_path   (launch),
        .store_en   (store_en),
        .pos        (pos_q),
        .bit_in     (store_bit),
        .save_path  (accept),
        .code_o     (rom_code),
        .path_bit_o (path_bit)
    );

    rse_branch #(.ROM_BITS(ROM_BITS)) u_branch (
        .clk        (clk),
        .rst        (rst),
        .init       (launch),
        .upd        (collide),
        .first_pass (first_q),
        .pos        (pos_q),
        .path_bit   (path_bit),
        .dir_o      (br_dir),
        .zero_o     (br_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            pos_q       <= '0;
            dbit_q      <= 1'b0;
            dir_q       <= 1'b0;
            single_q    <= 1'b1;
            first_q     <= 1'b1;
            more_q      <= 1'b0;
            status_q    <= RES_NONE;
            count_q     <= '0;
            rom_valid_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            rom_valid_q <= 1'b0;
            done_q      <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        single_q <= 1'b1;
                        first_q  <= 1'b1;
                        count_q  <= '0;
                        status_q <= RES_NONE;
                        state_q  <= ST_RESET;
                    end
                end
                ST_RESET: begin
                    if (cmd_done) begin
                        if (cmd_rbit) begin
                            pos_q   <= '0;
                            more_q  <= 1'b0;
                            state_q <= ST_CMD;
                        end else begin
                            status_q <= RES_ERROR;
                            count_q  <= '0;
                            done_q   <= 1'b1;
                            state_q  <= ST_IDLE;
                        end
                    end
                end
                ST_CMD: begin
                    if (cmd_done) state_q <= ST_RD_D;
                end
                ST_RD_D: begin
                    if (cmd_done) begin
                        dbit_q  <= cmd_rbit;
                        state_q <= ST_RD_C;
                    end
                end
                ST_RD_C: begin
                    if (cmd_done) begin
                        if (pair_err) begin
                            status_q <= RES_ERROR;
                            count_q  <= '0;
                            done_q   <= 1'b1;
                            state_q  <= ST_IDLE;
                        end else begin
                            dir_q <= store_bit;
                            if (collide) begin
                                single_q <= 1'b0;
                                if (br_zero) more_q <= 1'b1;
                            end
                            state_q <= ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (cmd_done) begin
                        if (pos_q == LAST_POS) begin
                            state_q <= ST_CHECK;
                        end else begin
                            pos_q   <= pos_q + 1'b1;
                            state_q <= ST_RD_D;
                        end
                    end
                end
                ST_CHECK: begin
                    if (!crc_ok) begin
                        status_q <= RES_ERROR;
                        count_q  <= '0;
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else begin
                        rom_valid_q <= 1'b1;
                        first_q     <= 1'b0;
                        if (count_q != CNT_MAX) count_q <= count_q + 1'b1;
                        if (single_q || !more_q) begin
                            status_q <= RES_LAST;
                            done_q   <= 1'b1;
                            state_q  <= ST_IDLE;
                        end else begin
                            state_q <= ST_RESET;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_valid = 1'b1;
        cmd_op    = OP_RESET;
        cmd_data  = 8'h00;
        unique case (state_q)
            ST_RESET: cmd_op = OP_RESET;
            ST_CMD: begin
                cmd_op   = OP_WBYTE;
                cmd_data = SEARCH_CMD;
            end
            ST_RD_D, ST_RD_C: cmd_op = OP_RBIT;
            ST_WR: begin
                cmd_op   = OP_WBIT;
                cmd_data = {7'b0, dir_q};
            end
            default: cmd_valid = 1'b0;
        endcase
    end

    assign rom_valid = rom_valid_q;
    assign dev_count = count_q;
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign status    = status_q;
endmodule

// File: rtl/rse_checker.sv
module rse_checker
    import rse_pkg::*;
#(
    parameter int ROM_BITS = 64,
    parameter int CNT_W    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_valid,
    input logic [1:0]          cmd_op,
    input logic [7:0]          cmd_data,
    input logic                cmd_done,
    input logic                rom_valid,
    input logic [ROM_BITS-1:0] rom_code,
    input logic [CNT_W-1:0]    dev_count,
    input logic                busy,
    input logic                done,
    input logic [1:0]          status
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    a_r2_hold_request: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data)));

    a_r6_crc_ok: assert property (@(posedge clk) disable iff (rst)
        rom_valid |-> (rom_code[63:56] == crc8_code7(rom_code[63:0])));

    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        rom_valid |-> (dev_count == (($past(dev_count) == CNT_MAX) ? CNT_MAX : $past(dev_count) + 1'b1)));

    a_r7_count_sat: assert property (@(posedge clk) disable iff (rst)
        (($past(dev_count) == CNT_MAX) && (dev_count != '0)) |-> (dev_count == CNT_MAX));

    a_r6_error_clears_count: assert property (@(posedge clk) disable iff (rst)
        (done && (status == RES_ERROR)) |-> (dev_count == '0));

    a_r8_done_status: assert property (@(posedge clk) disable iff (rst)
        done |-> ((status == RES_LAST) || (status == RES_ERROR)));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !cmd_valid);
endmodule

bind rom_search_engine rse_checker #(.ROM_BITS(ROM_BITS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .cmd_done  (cmd_done),
    .rom_valid (rom_valid),
    .rom_code  (rom_code),
    .dev_count (dev_count),
    .busy      (busy),
    .done      (done),
    .status    (status)
);

// File: tb/sim_rom_search_engine.sv
module sim_rom_search_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_data;
    logic        cmd_done;
    logic        cmd_rbit;
    logic        rom_valid;
    logic [63:0] rom_code;
    logic [7:0]  dev_count;
    logic        busy;
    logic        done;
    logic [1:0]  status;

    always #10 clk = ~clk;

    rom_search_engine u0 (
        .clk(clk), .rst(rst), .start(start),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .cmd_done(cmd_done), .cmd_rbit(cmd_rbit),
        .rom_valid(rom_valid), .rom_code(rom_code), .dev_count(dev_count),
        .busy(busy), .done(done), .status(status)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bus model state
    logic [63:0] dev [0:3];
    logic [3:0]  present = 4'b0;
    logic        ghost = 1'b0;
    logic [3:0]  active;
    int          bpos;
    bit          phase;
    int          bad_cmd = 0;

    // captured codes
    logic [63:0] got [0:255];
    int          ngot = 0;

    always @(negedge clk) begin
        if (rom_valid) begin
            if (ngot < 256) got[ngot] = rom_code;
            ngot++;
        end
    end

    function automatic logic [7:0] bench_crc(input logic [63:0] c);
        logic [7:0] r = 8'h00;
        for (int k = 0; k < 7; k++) begin
            r ^= c[8*k +: 8];
            for (int j = 0; j < 8; j++) r = r[0] ? ((r >> 1) ^ 8'h8C) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic [63:0] make_code(input logic [55:0] body);
        logic [63:0] c = {8'h00, body};
        c[63:56] = bench_crc(c);
        return c;
    endfunction

    function automatic logic [63:0] rev64(input logic [63:0] x);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = x[63-i];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic serve();
        logic r;
        case (cmd_op)
            2'd0: begin
                active = present; bpos = 0; phase = 0;
                cmd_rbit = ghost | (|present);
            end
            2'd1: begin
                if (cmd_data != 8'hF0) bad_cmd++;
                cmd_rbit = 1'b0;
            end
            2'd2: begin
                r = 1'b1;
                for (int k = 0; k < 4; k++)
                    if (active[k]) r &= phase ? ~dev[k][bpos] : dev[k][bpos];
                cmd_rbit = r;
                phase = ~phase;
            end
            default: begin
                for (int k = 0; k < 4; k++)
                    if (active[k] && (dev[k][bpos] != cmd_data[0])) active[k] = 1'b0;
                bpos++;
                phase = 0;
            end
        endcase
    endtask

    // slot engine model
    initial begin
        cmd_done = 1'b0;
        cmd_rbit = 1'b0;
        forever begin
            @(negedge clk);
            cmd_done = 1'b0;
            if (cmd_valid && !rst) begin
                repeat ($urandom_range(0, 2)) @(negedge clk);
                serve();
                cmd_done = 1'b1;
            end
        end
    end

    task automatic run_search(input string req, input logic [1:0] exp_st,
                              input int exp_n, input bit restart_mid);
        int base = ngot;
        int t = 0;
        logic [63:0] order [0:3];
        int n = 0;
        logic [3:0] used = 4'b0;
        // expected order: ascending by code read from bit 0 down
        for (int s = 0; s < 4; s++) begin
            int best = -1;
            for (int k = 0; k < 4; k++)
                if (present[k] && !used[k])
                    if (best < 0 || rev64(dev[k]) < rev64(dev[best])) best = k;
            if (best >= 0) begin
                used[best] = 1'b1; order[n] = dev[best]; n++;
            end
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R8 busy", {63'b0, busy}, 64'd1);
        while (!done && t < 40000) begin
            @(negedge clk); t++;
            if (restart_mid && t == 300) start = 1'b1;
            if (restart_mid && t == 301) start = 1'b0;
        end
        @(posedge clk); #1;
        if (t >= 40000) begin
            checks++; errors++;
            $display("FAIL %s timeout actual=busy expected=done", req);
        end
        check(status == exp_st, {req, " status"}, {62'b0, status}, {62'b0, exp_st});
        check(int'(dev_count) == exp_n, {req, " count"}, 64'(dev_count), 64'(exp_n));
        check((ngot - base) == exp_n, {req, " codes"}, 64'(ngot - base), 64'(exp_n));
        if (exp_st == 2'd1)
            for (int i = 0; i < exp_n; i++)
                check(got[base+i] == order[i], {req, " order"}, got[base+i], order[i]);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: idle after reset
        check(!busy && !done && !rom_valid && !cmd_valid, "R8 reset idle", {60'b0, busy, done, rom_valid, cmd_valid}, 64'd0);
        check(status == 2'd0 && dev_count == 8'd0, "R8 reset status", {54'b0, status, dev_count}, 64'd0);

        // R1: empty bus, no presence
        present = 4'b0; ghost = 1'b0;
        run_search("R1 no presence", 2'd2, 0, 0);

        // R3: presence but nobody answers bits
        ghost = 1'b1;
        run_search("R3 pair both ones", 2'd2, 0, 0);
        ghost = 1'b0;

        // R4: single device, no collisions
        dev[0] = make_code(56'h00_0000_0000_0001); present = 4'b0001;
        run_search("R4 single device", 2'd1, 1, 0);

        // R5: two devices differing at bit 0
        dev[0] = make_code(56'h12_3456_789A_BCDE);
        dev[1] = make_code(56'h12_3456_789A_BCDF); present = 4'b0011;
        run_search("R5 two devices", 2'd1, 2, 0);

        // R5: collisions deep in the code
        dev[0] = make_code(56'h80_0000_0000_0000);
        dev[1] = make_code(56'h00_0000_0000_0000);
        dev[2] = make_code(56'hC0_0000_0000_0000); present = 4'b0111;
        run_search("R5 deep branches", 2'd1, 3, 0);

        // R6: one device with a corrupted check byte
        dev[0] = make_code(56'h00_0000_0000_0001) ^ 64'h0100_0000_0000_0000; present = 4'b0001;
        run_search("R6 crc mismatch", 2'd2, 0, 0);

        // R9: start during a running search
        dev[0] = make_code(56'hAA_5555_AAAA_5555);
        dev[1] = make_code(56'h55_AAAA_5555_AAAA); present = 4'b0011;
        run_search("R9 start while busy", 2'd1, 2, 1);

        // R5/R7: random populations
        for (int trial = 0; trial < 16; trial++) begin
            present = 4'($urandom_range(1, 15));
            for (int k = 0; k < 4; k++) begin
                bit dup;
                do begin
                    dev[k] = make_code({$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF);
                    dup = 0;
                    for (int m = 0; m < k; m++) if (dev[m] == dev[k]) dup = 1;
                end while (dup);
            end
            run_search("R7 random population", 2'd1, $countones(present), 0);
        end

        // R2: every command byte was the search command
        check(bad_cmd == 0, "R2 command byte", 64'(bad_cmd), 64'd0);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule